// File: doc/BRIEF.md
# Staged Four-Channel PWM Bank

This block produces four independent pulse-width-modulated outputs from one base clock. Each channel is programmed with two 32-bit unsigned counts, a high time and a cycle length, both measured in base-clock ticks. Every cycle starts with the high phase and ends with the low phase. Software reaches the settings through a plain word-wide register port: address, write enable, write data and a registered read-data path.

Settings are held in staging registers and are not applied mid-cycle. A running channel picks up the staged pair only when its current cycle ends, so a rewrite never produces a truncated or stretched pulse. A channel whose active high time and cycle length are both zero is parked and holds its output high. A parked channel is restarted by writing the cycle length first and the high time second. The high-time write commits the pair on the next clock edge. Writing zero to both registers of a running channel parks it at the end of its current cycle.

Top module: `staged_pwm_bank`

## Requirements
- R1: A synchronous reset clears every staged and active value to zero and drives all four outputs high. Every register then reads back as zero.
- R2: For channel c, the high-time register is at byte address 8*c and the cycle-length register at 8*c+4. A read returns the last staged value on `rdata` one clock after the address is presented.
- R3: A parked channel loads its staged pair on the clock edge after a high-time write. The first tick of the new waveform appears on its output after that edge.
- R4: With a high time H and a cycle length P, where 0 < H < P, the output is high for H ticks and then low for P-H ticks, repeating every P ticks.
- R5: A register write to a running channel leaves the cycle in progress unchanged. The staged values apply from the first tick of the following cycle.
- R6: A channel whose active high time and cycle length are both zero holds its output high. Staging zeros into a running channel parks it at its next cycle boundary.
- R7: If H >= P with P nonzero, the output stays high for the whole cycle. If H = 0 with P nonzero, the output stays low for the whole cycle.
- R8: A write to an address that is not a multiple of 4, or that is at or above 0x20, changes nothing. A read from such an address returns zero.
- R9: The channels run independently. Writing or running one channel does not change another channel's output.
- R10: A parked channel that receives only a cycle-length write stays parked, with its output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte address of the register accessed |
| wdata | input | 32 | Data written when `wr_en` is high |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
A read result is due on `rdata` one edge after its address is sampled. A write takes effect in staging at the edge that samples it. For a parked channel, the first waveform tick is visible one edge after the high-time write edge. For a running channel, new values are visible from the edge that ends the cycle in progress. The bench computes every expected sample's absolute cycle number from these latencies before it drives the stimulus. It queues each sample with that number and compares it at the falling edge of that exact cycle. Reconfiguration writes are placed at known offsets from cycle boundaries, so the old and new patterns meet at a predictable tick.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
  // bytes occupied by one register and by one channel group
  localparam int BYTES_PER_REG = 4;
  localparam int CH_STRIDE     = 8;
  // address bit that picks the field inside a group, and lowest channel bit
  localparam int FLD_BIT = $clog2(BYTES_PER_REG);
  localparam int CH_LSB  = $clog2(CH_STRIDE);

  typedef enum logic {
    FLD_HIGH   = 1'b0,
    FLD_PERIOD = 1'b1
  } fld_e;
endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic [NCH-1:0][DW-1:0]  stg_hi,
  output logic [NCH-1:0][DW-1:0]  stg_per,
  output logic [NCH-1:0]          hi_commit
);
  import pwm_bank_pkg::*;

  localparam int CH_BITS = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] MAP_END = AW'(NCH * CH_STRIDE);

  logic               mapped;
  logic [CH_BITS-1:0] ch_sel;
  fld_e               fld;
  logic [DW-1:0]      rd_nxt;

  always_comb begin
    mapped = (addr[FLD_BIT-1:0] == '0) && (addr < MAP_END);
    ch_sel = addr[CH_LSB +: CH_BITS];
    fld    = fld_e'(addr[FLD_BIT]);
  end

  for (genvar g = 0; g < NCH; g++) begin : gen_stage
    logic hit;
    assign hit = wr_en && mapped && (ch_sel == CH_BITS'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        stg_hi[g]    <= '0;
        stg_per[g]   <= '0;
        hi_commit[g] <= 1'b0;
      end else begin
        if (hit && fld == FLD_HIGH)   stg_hi[g]  <= wdata;
        if (hit && fld == FLD_PERIOD) stg_per[g] <= wdata;
        hi_commit[g] <= hit && (fld == FLD_HIGH);
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (mapped) begin
      rd_nxt = (fld == FLD_PERIOD) ? stg_per[ch_sel] : stg_hi[ch_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
module pwm_bank_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] stg_hi,
  input  logic [DW-1:0] stg_per,
  input  logic          commit,
  output logic          pwm_o,
  output logic [DW-1:0] act_hi,
  output logic [DW-1:0] act_per,
  output logic [DW-1:0] act_cnt
);
  logic          parked, at_end, take;
  logic [DW-1:0] nxt_hi, nxt_per, nxt_cnt;
  logic          nxt_out;

  always_comb begin
    parked  = (act_per == '0) && (act_hi == '0);
    at_end  = (act_per == '0) || (act_cnt == act_per - 1'b1);
    // parked channels wait for the high-time write; running ones for the boundary
    take    = parked ? commit : at_end;
    nxt_hi  = take ? stg_hi  : act_hi;
    nxt_per = take ? stg_per : act_per;
    nxt_cnt = take ? '0      : act_cnt + 1'b1;
    nxt_out = ((nxt_per == '0) && (nxt_hi == '0)) || (nxt_cnt < nxt_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi  <= '0;
      act_per <= '0;
      act_cnt <= '0;
      pwm_o   <= 1'b1;
    end else begin
      act_hi  <= nxt_hi;
      act_per <= nxt_per;
      act_cnt <= nxt_cnt;
      pwm_o   <= nxt_out;
    end
  end
endmodule

// File: rtl/staged_pwm_bank.sv
`timescale 1ns/1ps
module staged_pwm_bank #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0][DW-1:0] stg_hi, stg_per;
  logic [NCH-1:0][DW-1:0] act_hi, act_per, act_cnt;
  logic [NCH-1:0]         hi_commit;

  pwm_bank_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .stg_hi    (stg_hi),
    .stg_per   (stg_per),
    .hi_commit (hi_commit)
  );

  for (genvar g = 0; g < NCH; g++) begin : gen_chan
    pwm_bank_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .stg_hi  (stg_hi[g]),
      .stg_per (stg_per[g]),
      .commit  (hi_commit[g]),
      .pwm_o   (pwm_out[g]),
      .act_hi  (act_hi[g]),
      .act_per (act_per[g]),
      .act_cnt (act_cnt[g])
    );
  end
endmodule

// File: rtl/staged_pwm_bank_chk.sv
`timescale 1ns/1ps
module staged_pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          rdata,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0][DW-1:0] act_hi,
  input logic [NCH-1:0][DW-1:0] act_per,
  input logic [NCH-1:0][DW-1:0] act_cnt
);
  localparam logic [AW-1:0] MAP_END = AW'(NCH * 8);

  // R1: reset drives every output high
  a_r1_reset_high: assert property (@(posedge clk) rst |=> (&pwm_out));

  // R8: unmapped reads return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    ((addr[1:0] != 2'b00) || (addr >= MAP_END)) |=> (rdata == '0));

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    // R6: parked channel holds high
    a_r6_parked_high: assert property (@(posedge clk) disable iff (rst)
      ((act_per[g] == '0) && (act_hi[g] == '0)) |-> pwm_out[g]);
    // R4: high phase comes first
    a_r4_high_phase: assert property (@(posedge clk) disable iff (rst)
      (act_cnt[g] < act_hi[g]) |-> pwm_out[g]);
    // R4 / R7: low phase after the high count
    a_r4_low_phase: assert property (@(posedge clk) disable iff (rst)
      (!((act_per[g] == '0) && (act_hi[g] == '0)) && (act_cnt[g] >= act_hi[g]))
        |-> !pwm_out[g]);
    // R5: tick count stays inside the cycle
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      (act_per[g] != '0) |-> (act_cnt[g] < act_per[g]));
    // R5: active values are held until the cycle ends
    a_r5_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
      ((act_per[g] != '0) && (act_cnt[g] < act_per[g] - 1'b1))
        |=> ($stable(act_per[g]) && $stable(act_hi[g])));
  end
endmodule

bind staged_pwm_bank staged_pwm_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .rdata   (rdata),
  .pwm_out (pwm_out),
  .act_hi  (act_hi),
  .act_per (act_per),
  .act_cnt (act_cnt)
);

// File: tb/sim_staged_pwm_bank.sv
`timescale 1ns/1ps
module sim_staged_pwm_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  staged_pwm_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    int          kind;   // 0: output bit of channel ch, 1: rdata
    int          ch;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int failures = 0;
  int last_at = 0;
  bit done = 1'b0;

  task automatic push(input int at, input int kind, input int ch,
                      input logic [31:0] v, input string tag);
    item_t it;
    it.at = at; it.kind = kind; it.ch = ch; it.val = v; it.tag = tag;
    sbq.push_back(it);
    if (at > last_at) last_at = at;
  endtask

  task automatic push_wave(input int start, input int ch, input int n,
                           input int per, input int hi, input string tag);
    for (int t = 0; t < n; t++)
      push(start + t, 0, ch, ((t % per) < hi) ? 32'd1 : 32'd0, tag);
  endtask

  // monitor: compares every queued item at its cycle
  initial begin
    forever begin
      @(negedge clk);
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].at == cyc) begin
          logic [31:0] act;
          act = (sbq[i].kind == 1) ? rdata : {31'b0, pwm_out[sbq[i].ch]};
          checks++;
          if (act !== sbq[i].val) begin
            failures++;
            $display("FAIL %s cyc=%0d kind=%0d ch=%0d actual=%0h expected=%0h",
                     sbq[i].tag, cyc, sbq[i].kind, sbq[i].ch, act, sbq[i].val);
          end
          sbq.delete(i);
        end
      end
    end
  end

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    push(cyc + 1, 1, 0, exp, tag);
    @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s, m, b0, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: outputs high and all registers zero after reset
    for (int ch = 0; ch < 4; ch++) push(cyc + 1, 0, ch, 32'd1, "R1");
    for (int r = 0; r < 8; r++) rd(8'(r * 4), 32'd0, "R1");

    // R10 then R3/R4: ch0 period 5, high 2
    n = cyc;
    push(n + 1, 0, 0, 32'd1, "R10");
    push(n + 2, 0, 0, 32'd1, "R10");
    s = n + 3;
    push_wave(s, 0, 10, 5, 2, "R4");
    wr(8'h04, 32'd5);
    wr(8'h00, 32'd2);

    // R5: restage in cycle 1, new values from tick s+10
    wait_until(s + 5);
    push_wave(s + 10, 0, 12, 4, 3, "R5");
    wr(8'h04, 32'd4);
    wr(8'h00, 32'd3);

    // R7: ch1 high >= period, ch2 high zero; R9: ch3 untouched
    m = cyc;
    push_wave(m + 3, 1, 9, 3, 3, "R7");
    push_wave(m + 5, 2, 12, 6, 0, "R7");
    push(m + 5, 0, 3, 32'd1, "R9");
    wr(8'h0C, 32'd3);
    wr(8'h08, 32'd5);
    wr(8'h14, 32'd6);
    wr(8'h10, 32'd0);

    // R2: readback of staged values
    rd(8'h00, 32'd3, "R2");
    rd(8'h04, 32'd4, "R2");
    rd(8'h08, 32'd5, "R2");
    rd(8'h0C, 32'd3, "R2");
    rd(8'h14, 32'd6, "R2");
    rd(8'h18, 32'd0, "R2");

    // R8: unmapped writes ignored, unmapped reads zero
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h01, 32'h0000_0077);
    wr(8'h1E, 32'h0000_0009);
    rd(8'h20, 32'd0, "R8");
    rd(8'h01, 32'd0, "R8");
    rd(8'h00, 32'd3, "R8");
    rd(8'h1C, 32'd0, "R8");
    push(cyc + 1, 0, 3, 32'd1, "R8");

    // R6: stage zeros right after a boundary, parked from the next one
    b0 = s + 10 + 4 * ((cyc - (s + 10) + 3) / 4);
    wait_until(b0);
    push(b0 + 1, 0, 0, 32'd1, "R6");
    push(b0 + 2, 0, 0, 32'd1, "R6");
    push(b0 + 3, 0, 0, 32'd0, "R6");
    push_wave(b0 + 4, 0, 8, 1, 1, "R6");
    wr(8'h04, 32'd0);
    wr(8'h00, 32'd0);

    // R3: restart the parked channel
    wait_until(b0 + 12);
    n = cyc;
    push(n + 1, 0, 0, 32'd1, "R3");
    push(n + 2, 0, 0, 32'd1, "R3");
    push_wave(n + 3, 0, 8, 2, 1, "R3");
    wr(8'h04, 32'd2);
    wr(8'h00, 32'd1);

    wait_until(last_at + 2);
    foreach (sbq[i]) begin
      failures++;
      $display("FAIL %s unchecked item cyc=%0d actual=none expected=%0h",
               sbq[i].tag, sbq[i].at, sbq[i].val);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule